// File: doc/BRIEF.md
# Byte-Wide EEPROM Page-Write Controller

This block sits on the device side of an asynchronous, byte-wide EEPROM interface with a 17-bit address. It oversamples the chip-enable, write-enable and output-enable strobes on a fast system clock and recognises write cycles. A write cycle can be controlled either by the write-enable pulse or by the chip-enable pulse. Accepted bytes are gathered into a page buffer. When no further byte arrives within a load timeout, the buffer is committed to a small internal storage array during a timed programming phase. While that phase runs, reads return polling status instead of array data.

A software protection scheme guards the array. A three-write command prefix turns protection on and also opens a page write. A six-write command sequence turns protection off. While protection is on, only bytes that follow the prefix are stored. The load timeout, the programming time, the page size and the array size are parameters, and the strobe synchroniser depth can be chosen.

Top module: `eeprom_page_ctrl`

## Requirements
- R1: A write cycle exists while chip-enable and write-enable are both low and output-enable is high. Either strobe may be the one that starts and ends the cycle. The address is taken when the cycle begins and the data byte when it ends, so an address change in mid-cycle has no effect.
- R2: A write attempt with output-enable low, or with chip-enable held high, stores nothing and starts no programming.
- R3: A page write loads 1 to 2^PAGE_AW bytes (128 by default). Each byte restarts a LOAD_TIMEOUT-cycle timer. When that timer expires, programming runs for PROG_CYCLES cycles, after which every loaded byte reads back from the array.
- R4: The first byte of a page fixes its page tag, which is address bits 16..7. Later bytes with a different tag are ignored, both as data and as the source of the polling bit.
- R5: While programming runs, a read returns the inverse of bit 7 of the last accepted byte on bit 7. Bit 6 reads 1 on the first status read and alternates on each read after that. Bits 5..0 read 0.
- R6: Write cycles that occur while programming runs are ignored.
- R7: The writes AA@5555, 55@2AAA, A0@5555 turn protection on. Command addresses are compared on address bits 14..0. The bytes that follow form a normal page write, and the command writes themselves are never stored.
- R8: While protection is on, a data write without the prefix is discarded. The following read returns array data, not status.
- R9: The writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 20@5555 turn protection off without starting programming. After that, plain writes are accepted again.
- R10: After reset, dout is 0 and dout_en is low. dout_en is high while a read cycle is active (chip-enable low, output-enable low, write-enable high). dout is 0 when no read is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 17 | Byte address |
| din | input | 8 | Write data from the host |
| dout | output | 8 | Read data or polling status |
| dout_en | output | 1 | High while a read cycle drives dout |

## Verification
Strobes pass through SYNC_STAGES registers and one edge-detect stage. Read data therefore appears on dout about three clocks after chip-enable and output-enable fall, so the bench holds each read for five clocks and samples at the falling clock edge. A write is acted on about three clocks after its closing strobe edge. Programming ends LOAD_TIMEOUT plus PROG_CYCLES clocks after the last accepted byte, so completion waits use that sum plus a margin.

Status reads are placed 45 clocks after the last byte. That is past the 40-cycle timeout of the bench but well inside the 160-cycle programming phase. Discarded and blocked writes are checked twice. A read right after the write must return array data, which would be status if programming had started. A second read after a full programming window must show the old contents.

// File: rtl/eep_pkg.sv
package eep_pkg;
   typedef enum logic [1:0] {
      LD_IDLE = 2'd0,
      LD_FILL = 2'd1,
      LD_PROG = 2'd2
   } ld_state_t;

   localparam logic [14:0] CMD_ADDR_A = 15'h5555;
   localparam logic [14:0] CMD_ADDR_B = 15'h2AAA;
   localparam logic [7:0]  CMD_KEY1   = 8'hAA;
   localparam logic [7:0]  CMD_KEY2   = 8'h55;
   localparam logic [7:0]  CMD_LOCK   = 8'hA0;
   localparam logic [7:0]  CMD_EXT    = 8'h80;
   localparam logic [7:0]  CMD_UNLOCK = 8'h20;
endpackage

// File: rtl/eep_strobe_if.sv
module eep_strobe_if #(
   parameter int ADDR_W      = 17,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        din,
   output logic              wr_ev,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data,
   output logic              rd_act,
   output logic              rd_start,
   output logic [ADDR_W-1:0] rd_addr
);
   localparam int BW = ADDR_W + 11;
   localparam logic [BW-1:0] BUS_IDLE = {3'b111, {(ADDR_W+8){1'b0}}};

   initial assert (SYNC_STAGES == 1 || SYNC_STAGES == 2)
      else $error("SYNC_STAGES must be 1 or 2");

   logic [BW-1:0] raw_bus, s_bus;
   assign raw_bus = {ce_n, we_n, oe_n, addr, din};

   generate
      if (SYNC_STAGES == 1) begin : g_sync1
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_bus <= BUS_IDLE;
            else        s_bus <= raw_bus;
         end
      end else begin : g_sync2
         logic [BW-1:0] meta_bus;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               meta_bus <= BUS_IDLE;
               s_bus    <= BUS_IDLE;
            end else begin
               meta_bus <= raw_bus;
               s_bus    <= meta_bus;
            end
         end
      end
   endgenerate

   logic s_ce, s_we, s_oe;
   logic [ADDR_W-1:0] s_addr;
   assign s_ce   = s_bus[BW-1];
   assign s_we   = s_bus[BW-2];
   assign s_oe   = s_bus[BW-3];
   assign s_addr = s_bus[ADDR_W+7:8];

   logic wr_act, wr_act_q, rd_act_q;
   logic [ADDR_W-1:0] cap_addr;

   assign wr_act = !s_ce && !s_we && s_oe;
   assign rd_act = !s_ce && !s_oe && s_we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_act_q <= 1'b0;
         rd_act_q <= 1'b0;
         cap_addr <= '0;
      end else begin
         wr_act_q <= wr_act;
         rd_act_q <= rd_act;
         if (wr_act && !wr_act_q) cap_addr <= s_addr;
      end
   end

   assign wr_ev    = wr_act_q && !wr_act;
   assign wr_addr  = cap_addr;
   assign wr_data  = s_bus[7:0];
   assign rd_start = rd_act && !rd_act_q;
   assign rd_addr  = s_addr;

   assert_addr_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_act_q && $past(wr_act_q)) |-> $stable(cap_addr));
endmodule

// File: rtl/eep_sdp_seq.sv
module eep_sdp_seq
   import eep_pkg::*;
#(
   parameter int ADDR_W     = 17,
   parameter int GAP_CYCLES = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ev,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              loading,
   input  logic              busy,
   output logic              data_ok
);
   localparam int GW = $clog2(GAP_CYCLES + 1);

   initial assert (ADDR_W >= 15 && GAP_CYCLES >= 2)
      else $error("ADDR_W must cover the command addresses");

   logic [2:0]    step;
   logic          armed, prot;
   logic [GW-1:0] gap;
   logic [14:0]   exp_addr;
   logic [7:0]    exp_data;
   logic          hit;
   logic          unused_hi;

   assign unused_hi = ^wr_addr[ADDR_W-1:15];

   always_comb begin
      exp_addr = CMD_ADDR_A;
      exp_data = CMD_KEY1;
      case (step)
         3'd1, 3'd4: begin exp_addr = CMD_ADDR_B; exp_data = CMD_KEY2; end
         3'd2:       exp_data = CMD_LOCK;
         3'd5:       exp_data = CMD_UNLOCK;
         default:    ;
      endcase
   end

   assign hit = (wr_addr[14:0] == exp_addr) &&
                ((wr_data == exp_data) || (step == 3'd2 && wr_data == CMD_EXT));

   assign data_ok = wr_ev && !busy && (loading || armed || (!hit && !prot));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step  <= '0;
         armed <= 1'b0;
         prot  <= 1'b0;
         gap   <= '0;
      end else if (wr_ev && !busy) begin
         gap <= '0;
         if (loading || armed) begin
            armed <= 1'b0;
         end else if (hit) begin
            case (step)
               3'd2: begin
                  if (wr_data == CMD_LOCK) begin
                     prot  <= 1'b1;
                     armed <= 1'b1;
                     step  <= '0;
                  end else begin
                     step <= 3'd3;
                  end
               end
               3'd5: begin
                  prot <= 1'b0;
                  step <= '0;
               end
               default: step <= step + 3'd1;
            endcase
         end else begin
            step <= '0;
         end
      end else if (step != 3'd0 || armed) begin
         if (gap == GW'(GAP_CYCLES - 1)) begin
            step  <= '0;
            armed <= 1'b0;
            gap   <= '0;
         end else begin
            gap <= gap + GW'(1);
         end
      end
   end

   assert_lock_by_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prot) |-> $past(wr_ev));
   assert_unlock_by_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(prot) |-> ($past(wr_ev) && !$past(data_ok)));
endmodule

// File: rtl/eep_page_loader.sv
module eep_page_loader
   import eep_pkg::*;
#(
   parameter int ADDR_W       = 17,
   parameter int PAGE_AW      = 7,
   parameter int LOAD_TIMEOUT = 64,
   parameter int PROG_CYCLES  = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              data_ok,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   output logic              busy,
   output logic              loading,
   output logic              last_b7,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata
);
   localparam int PAGE_BYTES = 1 << PAGE_AW;
   localparam int TAG_W      = ADDR_W - PAGE_AW;
   localparam int TMAX       = (LOAD_TIMEOUT > PROG_CYCLES) ? LOAD_TIMEOUT : PROG_CYCLES;
   localparam int TW         = $clog2(TMAX + 1);

   initial assert (PROG_CYCLES >= PAGE_BYTES && LOAD_TIMEOUT >= 2 && PAGE_AW < ADDR_W)
      else $error("programming window must cover one byte per page slot");

   ld_state_t             state;
   logic [TAG_W-1:0]      tag;
   logic [PAGE_BYTES-1:0] vld;
   logic [7:0]            pbuf [PAGE_BYTES];
   logic [TW-1:0]         tmr;

   logic [PAGE_AW-1:0] idx, sidx;
   logic [TAG_W-1:0]   wtag;
   logic               same_pg, take;

   assign idx     = wr_addr[PAGE_AW-1:0];
   assign wtag    = wr_addr[ADDR_W-1:PAGE_AW];
   assign same_pg = (wtag == tag);
   assign take    = data_ok && ((state == LD_IDLE) || (state == LD_FILL && same_pg));
   assign sidx    = tmr[PAGE_AW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= LD_IDLE;
         tag     <= '0;
         vld     <= '0;
         tmr     <= '0;
         last_b7 <= 1'b0;
      end else begin
         case (state)
            LD_IDLE: begin
               if (data_ok) begin
                  tag     <= wtag;
                  vld     <= PAGE_BYTES'(1) << idx;
                  last_b7 <= wr_data[7];
                  tmr     <= '0;
                  state   <= LD_FILL;
               end
            end
            LD_FILL: begin
               if (take) begin
                  vld[idx] <= 1'b1;
                  last_b7  <= wr_data[7];
                  tmr      <= '0;
               end else if (tmr == TW'(LOAD_TIMEOUT - 1)) begin
                  tmr   <= '0;
                  state <= LD_PROG;
               end else begin
                  tmr <= tmr + TW'(1);
               end
            end
            LD_PROG: begin
               if (tmr == TW'(PROG_CYCLES - 1)) begin
                  tmr   <= '0;
                  vld   <= '0;
                  state <= LD_IDLE;
               end else begin
                  tmr <= tmr + TW'(1);
               end
            end
            default: state <= LD_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (take) pbuf[idx] <= wr_data;
   end

   assign busy      = (state == LD_PROG);
   assign loading   = (state == LD_FILL);
   assign mem_we    = busy && (tmr < TW'(PAGE_BYTES)) && vld[sidx];
   assign mem_addr  = {tag, sidx};
   assign mem_wdata = pbuf[sidx];

   assert_no_accept_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !data_ok);
   assert_tag_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state != LD_IDLE && $past(state) != LD_IDLE) |-> $stable(tag));
   assert_foreign_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == LD_FILL && data_ok && !same_pg) |=> $stable(vld));
   assert_page_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == LD_PROG && state == LD_IDLE) |-> (vld == '0));
endmodule

// File: rtl/eeprom_page_ctrl.sv
module eeprom_page_ctrl #(
   parameter int ADDR_W       = 17,
   parameter int PAGE_AW      = 7,
   parameter int MEM_AW       = 10,
   parameter int LOAD_TIMEOUT = 64,
   parameter int PROG_CYCLES  = 256,
   parameter int SYNC_STAGES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        din,
   output logic [7:0]        dout,
   output logic              dout_en
);
   localparam int MEM_DEPTH = 1 << MEM_AW;

   initial assert (MEM_AW >= PAGE_AW && MEM_AW < ADDR_W && MEM_AW <= 12)
      else $error("array size out of range");

   logic              wr_ev, rd_act, rd_start, data_ok;
   logic [ADDR_W-1:0] wr_addr, rd_addr, mem_addr;
   logic [7:0]        wr_data, mem_wdata;
   logic              busy, loading, last_b7, mem_we;

   eep_strobe_if #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) i_strobe (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .addr(addr), .din(din), .wr_ev(wr_ev), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_act(rd_act), .rd_start(rd_start), .rd_addr(rd_addr));

   eep_sdp_seq #(.ADDR_W(ADDR_W), .GAP_CYCLES(LOAD_TIMEOUT)) i_seq (
      .clk(clk), .rst_n(rst_n), .wr_ev(wr_ev), .wr_addr(wr_addr), .wr_data(wr_data),
      .loading(loading), .busy(busy), .data_ok(data_ok));

   eep_page_loader #(.ADDR_W(ADDR_W), .PAGE_AW(PAGE_AW),
                     .LOAD_TIMEOUT(LOAD_TIMEOUT), .PROG_CYCLES(PROG_CYCLES)) i_loader (
      .clk(clk), .rst_n(rst_n), .data_ok(data_ok), .wr_addr(wr_addr), .wr_data(wr_data),
      .busy(busy), .loading(loading), .last_b7(last_b7), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata));

   logic [7:0] mem [MEM_DEPTH];
   logic       unused_addr;
   assign unused_addr = ^{rd_addr[ADDR_W-1:MEM_AW], mem_addr[ADDR_W-1:MEM_AW]};

   always_ff @(posedge clk) begin
      if (mem_we) mem[mem_addr[MEM_AW-1:0]] <= mem_wdata;
   end

   logic tog, busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tog     <= 1'b0;
         busy_q  <= 1'b0;
         dout    <= 8'h00;
         dout_en <= 1'b0;
      end else begin
         busy_q  <= busy;
         dout_en <= rd_act;
         if (busy && !busy_q)      tog <= 1'b0;
         else if (rd_start && busy) tog <= ~tog;
         if (!rd_act)   dout <= 8'h00;
         else if (busy) dout <= {~last_b7, tog, 6'b000000};
         else           dout <= mem[rd_addr[MEM_AW-1:0]];
      end
   end

   assert_status_low_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy) && $past(rd_act)) |-> (dout[5:0] == 6'd0));
   assert_array_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (loading || !busy) |-> !mem_we);
   assert_idle_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rd_act) |-> (!dout_en && dout == 8'h00));
endmodule

// File: tb/test_eeprom_page_ctrl.sv
module test_eeprom_page_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int LOAD_TO    = 40;
   localparam int PROG_CYC   = 160;
   localparam int DONE_WAIT  = LOAD_TO + PROG_CYC + 20;

   localparam logic [3:0] OP_W    = 4'd1;  // write, WE-controlled
   localparam logic [3:0] OP_C    = 4'd2;  // write, CE-controlled
   localparam logic [3:0] OP_R    = 4'd3;  // read and compare
   localparam logic [3:0] OP_S    = 4'd4;  // status read and compare
   localparam logic [3:0] OP_DONE = 4'd5;  // wait for programming to end
   localparam logic [3:0] OP_WAIT = 4'd6;  // wait data cycles
   localparam logic [3:0] OP_MOVE = 4'd7;  // write with address moved mid-cycle
   localparam logic [3:0] OP_BOE  = 4'd8;  // write attempt with OE low
   localparam logic [3:0] OP_BCE  = 4'd9;  // write attempt with CE high

   localparam int NV = 59;
   // {req[40:37], op[36:33], addr[32:16], data[15:8], exp[7:0]}
   localparam logic [40:0] VEC [NV] = '{
      {4'd3, OP_W,    17'h00090, 8'h5A, 8'h00},  // R3 single-byte page
      {4'd5, OP_WAIT, 17'h00000, 8'd45, 8'h00},
      {4'd5, OP_S,    17'h00090, 8'h00, 8'hC0},  // R5 first poll
      {4'd5, OP_S,    17'h00090, 8'h00, 8'h80},  // R5 toggle
      {4'd3, OP_DONE, 17'h00000, 8'h00, 8'h00},
      {4'd3, OP_W,    17'h00012, 8'h66, 8'h00},
      {4'd3, OP_DONE, 17'h00000, 8'h00, 8'h00},
      {4'd1, OP_W,    17'h00010, 8'h3C, 8'h00},  // R1 WE-controlled
      {4'd1, OP_C,    17'h00011, 8'hA5, 8'h00},  // R1 CE-controlled
      {4'd3, OP_W,    17'h0007F, 8'h81, 8'h00},
      {4'd4, OP_W,    17'h00090, 8'h77, 8'h00},  // R4 other page
      {4'd5, OP_WAIT, 17'h00000, 8'd45, 8'h00},
      {4'd5, OP_S,    17'h00000, 8'h00, 8'h40},  // R5 last accepted 0x81
      {4'd5, OP_S,    17'h00000, 8'h00, 8'h00},
      {4'd6, OP_W,    17'h00012, 8'h11, 8'h00},  // R6 write while busy
      {4'd3, OP_DONE, 17'h00000, 8'h00, 8'h00},
      {4'd1, OP_R,    17'h00010, 8'h00, 8'h3C},
      {4'd1, OP_R,    17'h00011, 8'h00, 8'hA5},
      {4'd3, OP_R,    17'h0007F, 8'h00, 8'h81},
      {4'd4, OP_R,    17'h00090, 8'h00, 8'h5A},
      {4'd6, OP_R,    17'h00012, 8'h00, 8'h66},
      {4'd1, OP_MOVE, 17'h00040, 8'hC3, 8'h00},  // R1 address taken at start
      {4'd1, OP_DONE, 17'h00000, 8'h00, 8'h00},
      {4'd1, OP_R,    17'h00040, 8'h00, 8'hC3},
      {4'd2, OP_BOE,  17'h00010, 8'hEE, 8'h00},  // R2 OE low
      {4'd2, OP_BCE,  17'h00010, 8'hEF, 8'h00},  // R2 CE high
      {4'd2, OP_R,    17'h00010, 8'h00, 8'h3C},
      {4'd2, OP_WAIT, 17'h00000, 8'd230, 8'h00},
      {4'd2, OP_R,    17'h00010, 8'h00, 8'h3C},
      {4'd7, OP_W,    17'h05555, 8'hAA, 8'h00},  // R7 lock prefix
      {4'd7, OP_W,    17'h02AAA, 8'h55, 8'h00},
      {4'd7, OP_W,    17'h05555, 8'hA0, 8'h00},
      {4'd7, OP_W,    17'h00020, 8'h12, 8'h00},
      {4'd7, OP_W,    17'h00021, 8'h34, 8'h00},
      {4'd7, OP_WAIT, 17'h00000, 8'd45, 8'h00},
      {4'd7, OP_S,    17'h00000, 8'h00, 8'hC0},
      {4'd7, OP_DONE, 17'h00000, 8'h00, 8'h00},
      {4'd7, OP_R,    17'h00020, 8'h00, 8'h12},
      {4'd7, OP_R,    17'h00021, 8'h00, 8'h34},
      {4'd8, OP_W,    17'h00020, 8'h99, 8'h00},  // R8 unprefixed while locked
      {4'd8, OP_R,    17'h00020, 8'h00, 8'h12},
      {4'd8, OP_WAIT, 17'h00000, 8'd230, 8'h00},
      {4'd8, OP_R,    17'h00020, 8'h00, 8'h12},
      {4'd7, OP_W,    17'h05555, 8'hAA, 8'h00},  // R7 prefixed write while locked
      {4'd7, OP_W,    17'h02AAA, 8'h55, 8'h00},
      {4'd7, OP_W,    17'h05555, 8'hA0, 8'h00},
      {4'd7, OP_W,    17'h00020, 8'h56, 8'h00},
      {4'd7, OP_DONE, 17'h00000, 8'h00, 8'h00},
      {4'd7, OP_R,    17'h00020, 8'h00, 8'h56},
      {4'd9, OP_W,    17'h05555, 8'hAA, 8'h00},  // R9 unlock sequence
      {4'd9, OP_W,    17'h02AAA, 8'h55, 8'h00},
      {4'd9, OP_W,    17'h05555, 8'h80, 8'h00},
      {4'd9, OP_W,    17'h05555, 8'hAA, 8'h00},
      {4'd9, OP_W,    17'h02AAA, 8'h55, 8'h00},
      {4'd9, OP_W,    17'h05555, 8'h20, 8'h00},
      {4'd9, OP_R,    17'h00020, 8'h00, 8'h56},
      {4'd9, OP_W,    17'h00021, 8'h78, 8'h00},
      {4'd9, OP_DONE, 17'h00000, 8'h00, 8'h00},
      {4'd9, OP_R,    17'h00021, 8'h00, 8'h78}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [16:0] addr = '0;
   logic [7:0]  din = '0;
   logic [7:0]  dout;
   logic        dout_en;
   int          total = 0, bad = 0;
   bit          finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   eeprom_page_ctrl #(.LOAD_TIMEOUT(LOAD_TO), .PROG_CYCLES(PROG_CYC)) i_eeprom_page_ctrl (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .addr(addr), .din(din), .dout(dout), .dout_en(dout_en));

   task automatic check(input int req, input string what, input logic [7:0] got, input logic [7:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL R%0d %s: actual=%h expected=%h", req, what, got, exp);
      end
   endtask

   task automatic ticks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_we(input logic [16:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; din = d; oe_n = 1'b1; ce_n = 1'b0;
      @(negedge clk); we_n = 1'b0;
      ticks(3);       we_n = 1'b1;
      @(negedge clk); ce_n = 1'b1;
      ticks(2);
   endtask

   task automatic wr_ce(input logic [16:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; din = d; oe_n = 1'b1; we_n = 1'b0;
      @(negedge clk); ce_n = 1'b0;
      ticks(3);       ce_n = 1'b1;
      @(negedge clk); we_n = 1'b1;
      ticks(2);
   endtask

   task automatic wr_move(input logic [16:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; din = d; oe_n = 1'b1; ce_n = 1'b0;
      @(negedge clk); we_n = 1'b0;
      ticks(2);       addr = a + 17'd1;
      ticks(2);       we_n = 1'b1;
      @(negedge clk); ce_n = 1'b1;
      ticks(2);
   endtask

   task automatic wr_blocked(input bit oe_low, input logic [16:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; din = d;
      oe_n = oe_low ? 1'b0 : 1'b1; ce_n = oe_low ? 1'b0 : 1'b1;
      @(negedge clk); we_n = 1'b0;
      ticks(3);       we_n = 1'b1;
      @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
      ticks(4);
   endtask

   task automatic rd(input logic [16:0] a, output logic [7:0] val, output logic en);
      @(negedge clk); addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
      ticks(5);
      val = dout; en = dout_en;
      ce_n = 1'b1; oe_n = 1'b1;
      ticks(4);
   endtask

   initial begin
      ticks(CLK_PERIOD * 15000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      logic       en;
      ticks(3);
      // R10 reset state
      check(10, "reset dout", dout, 8'h00);
      check(10, "reset dout_en", {7'd0, dout_en}, 8'h01 ^ 8'h01);
      rst_n = 1'b1;
      ticks(2);

      for (int i = 0; i < NV; i++) begin
         int          req;
         logic [3:0]  op;
         logic [16:0] a;
         logic [7:0]  d, e;
         req = int'(VEC[i][40:37]);
         op  = VEC[i][36:33];
         a   = VEC[i][32:16];
         d   = VEC[i][15:8];
         e   = VEC[i][7:0];
         case (op)
            OP_W:    wr_we(a, d);
            OP_C:    wr_ce(a, d);
            OP_MOVE: wr_move(a, d);
            OP_BOE:  wr_blocked(1'b1, a, d);
            OP_BCE:  wr_blocked(1'b0, a, d);
            OP_DONE: ticks(DONE_WAIT);
            OP_WAIT: ticks(int'(d));
            OP_R:    begin rd(a, v, en); check(req, $sformatf("vec %0d read %h", i, a), v, e); end
            OP_S:    begin rd(a, v, en); check(req, $sformatf("vec %0d status", i), v, e); end
            default: ;
         endcase
      end

      // R3 full 128-byte page
      for (int k = 0; k < 128; k++) wr_we(17'h00100 + 17'(k), 8'(k) ^ 8'hC5);
      ticks(DONE_WAIT);
      rd(17'h00100, v, en); check(3, "page byte 0", v, 8'hC5);
      rd(17'h00140, v, en); check(3, "page byte 64", v, 8'h40 ^ 8'hC5);
      rd(17'h0017F, v, en); check(3, "page byte 127", v, 8'h7F ^ 8'hC5);

      // R10 output enable during and after a read
      @(negedge clk); addr = 17'h00010; ce_n = 1'b0; oe_n = 1'b0;
      ticks(5);
      check(10, "dout_en in read", {7'd0, dout_en}, 8'h01);
      ce_n = 1'b1; oe_n = 1'b1;
      ticks(5);
      check(10, "dout_en after read", {7'd0, dout_en}, 8'h00);
      check(10, "dout after read", dout, 8'h00);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule